// File: doc/BRIEF.md
# Long-Word Bus Splitter with Mid-Access Yield

This block sits between a processing core that issues 32-bit loads and stores and a bus that carries only 16 bits per cycle. It accepts one request at a time. A 32-bit request becomes two word cycles: the high half goes first at the given address, and the low half follows at the address plus two. A 16-bit request becomes a single word cycle. The core sees one acknowledge, raised only after every word cycle of its request has finished. For a read, that acknowledge comes with the assembled 32-bit value.

A second bus master can ask for the bus with a request line. The block looks at that line in a one-cycle gap that follows every word cycle, and also while it is idle. If the line is high, the block parks the bus with all drive lines at zero and raises grant. It keeps grant high until the request drops, then removes grant and continues the interrupted access. The bus can therefore change hands in the middle of a single long access, between its two halves. A device that asks for the bus in reaction to the first half of a write gets the bus before the second half arrives. The gap after the last word also comes before the core acknowledge, so a device that asks for the bus after a read is granted before the core can issue its next access.

The controller has five states. The transitions are named as follows:
- IDLE goes to YIELD on a bus request (*idle_yield*). Otherwise a core request loads the access and IDLE goes to WORD (*accept*).
- WORD goes to GAP when the bus acknowledges (*word_end*).
- GAP goes to YIELD on a bus request (*gap_yield*). Otherwise GAP goes to WORD if words remain (*next_word*), or to DONE if none remain (*finish*).
- YIELD goes back to IDLE, WORD or DONE once the request drops (*release*). The target depends on whether an access is open and whether words remain.
- DONE goes to IDLE (*retire*).

Top module: `lw_split_yield`

## Requirements
- R1: After reset, bus_stb, bus_we, bus_addr, bus_wdata, ext_bgnt, core_ack and core_rdata are all zero.
- R2: A request with core_long=1 produces exactly two word cycles. The first is at core_addr and carries core_wdata[31:16]. The second is at core_addr+2 and carries core_wdata[15:0].
- R3: A request with core_long=0 produces exactly one word cycle, at core_addr, carrying core_wdata[15:0]. For a read, the returned value is {16'h0, word}.
- R4: core_ack is high for exactly one cycle, after the last word cycle has been acknowledged. For a long read, core_rdata = {first word read, second word read}.
- R5: Once bus_stb is high, bus_stb, bus_addr, bus_we and bus_wdata stay unchanged until the cycle in which bus_ack is high. A word cycle is never abandoned, even if ext_breq rises during it.
- R6: Every acknowledged word cycle is followed by a cycle with bus_stb low. If ext_breq is high in that cycle, ext_bgnt rises on the next cycle, which is two cycles after the acknowledging cycle. Grant never rises while a word cycle is in progress.
- R7: While ext_bgnt is high, bus_stb, bus_we, bus_addr and bus_wdata are all zero.
- R8: ext_bgnt falls in the cycle after ext_breq is first seen low. If a word of the open access remains, its bus_stb rises in that same cycle.
- R9: A yield requested in the gap after the final word is served before core_ack. core_ack appears in the cycle in which grant falls.
- R10: In IDLE, ext_breq takes priority over core_req: grant rises one cycle after the request, and no word cycle starts until grant has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | 1 | Core access request, held until core_ack |
| core_we | input | 1 | 1 = write, 0 = read |
| core_long | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| core_addr | input | ADDR_W | Byte address of the access (even) |
| core_wdata | input | CORE_W | Write data |
| core_ack | output | 1 | One-cycle completion pulse |
| core_rdata | output | CORE_W | Read result, valid while core_ack is high |
| bus_stb | output | 1 | Word cycle strobe |
| bus_we | output | 1 | Word cycle direction |
| bus_addr | output | ADDR_W | Word cycle address |
| bus_wdata | output | BUS_W | Word cycle write data |
| bus_ack | input | 1 | Word cycle completion from the slave |
| bus_rdata | input | BUS_W | Word read data, valid with bus_ack |
| ext_breq | input | 1 | Bus request from another master |
| ext_bgnt | output | 1 | Bus grant to the other master |

## Verification
The properties assume that the slave raises bus_ack only while bus_stb is high, and only for a single cycle. They also assume that core_req stays high until core_ack, and that the core drops it as the pulse arrives. The bench slave model waits a programmable number of strobe cycles, pulses bus_ack once, and never acknowledges an idle bus. The core driver drops its request on the same half-cycle in which it sees the acknowledge. The external master raises its request only at the first cycle of a chosen word, or while the block is idle. It holds the request through the grant and then releases it, so the grant-cause and release properties see well-formed request/grant handshakes.

// File: rtl/lwsy_pkg.sv
package lwsy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WORD  = 3'd1,
        ST_GAP   = 3'd2,
        ST_YIELD = 3'd3,
        ST_DONE  = 3'd4
    } lwsy_state_e;

endpackage

// File: rtl/lwsy_fsm.sv
module lwsy_fsm
    import lwsy_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        core_req,
    input  logic        ext_breq,
    input  logic        bus_ack,
    input  logic        words_left_zero,
    output lwsy_state_e state,
    output logic        load,
    output logic        word_done
);

    lwsy_state_e state_q;
    lwsy_state_e state_d;
    logic        open_q;

    // State register and open-access flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            open_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load)
                open_q <= 1'b1;
            else if (state_q == ST_DONE)
                open_q <= 1'b0;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ext_breq)
                    state_d = ST_YIELD;       // idle_yield
                else if (core_req)
                    state_d = ST_WORD;        // accept
            end
            ST_WORD: begin
                if (bus_ack)
                    state_d = ST_GAP;         // word_end
            end
            ST_GAP: begin
                if (ext_breq)
                    state_d = ST_YIELD;       // gap_yield
                else if (!words_left_zero)
                    state_d = ST_WORD;        // next_word
                else
                    state_d = ST_DONE;        // finish
            end
            ST_YIELD: begin
                if (!ext_breq) begin          // release
                    if (!open_q)
                        state_d = ST_IDLE;
                    else if (!words_left_zero)
                        state_d = ST_WORD;
                    else
                        state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;       // retire
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        state     = state_q;
        load      = (state_q == ST_IDLE) && !ext_breq && core_req;
        word_done = (state_q == ST_WORD) && bus_ack;
    end

endmodule

// File: rtl/lwsy_xfer.sv
module lwsy_xfer #(
    parameter int ADDR_W = 24,
    parameter int CORE_W = 32,
    parameter int BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              word_done,
    input  logic              core_we,
    input  logic              core_long,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [CORE_W-1:0] core_wdata,
    input  logic [BUS_W-1:0]  bus_rdata,
    output logic [ADDR_W-1:0] word_addr,
    output logic [BUS_W-1:0]  word_data,
    output logic              word_we,
    output logic [CORE_W-1:0] read_word,
    output logic              words_left_zero
);

    localparam int BEATS = CORE_W / BUS_W;
    localparam int CNT_W = $clog2(BEATS + 1);
    localparam int STEP  = BUS_W / 8;

    logic [ADDR_W-1:0] addr_q;
    logic [CORE_W-1:0] wbuf_q;
    logic [CORE_W-1:0] rbuf_q;
    logic [CNT_W-1:0]  left_q;
    logic              we_q;

    logic [CORE_W-1:0] short_img;
    logic [CORE_W-1:0] wbuf_shift;
    logic [CORE_W-1:0] rbuf_next;

    // Short writes place the single word where the first beat is taken from
    generate
        if (BEATS > 1) begin : g_multi
            assign short_img  = {core_wdata[BUS_W-1:0], {(CORE_W-BUS_W){1'b0}}};
            assign wbuf_shift = {wbuf_q[CORE_W-BUS_W-1:0], {BUS_W{1'b0}}};
            assign rbuf_next  = {rbuf_q[CORE_W-BUS_W-1:0], bus_rdata};
        end else begin : g_single
            assign short_img  = core_wdata;
            assign wbuf_shift = '0;
            assign rbuf_next  = bus_rdata;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            wbuf_q <= '0;
            rbuf_q <= '0;
            left_q <= '0;
            we_q   <= 1'b0;
        end else if (load) begin
            addr_q <= core_addr;
            wbuf_q <= core_long ? core_wdata : short_img;
            rbuf_q <= '0;
            left_q <= core_long ? CNT_W'(BEATS) : CNT_W'(1);
            we_q   <= core_we;
        end else if (word_done) begin
            addr_q <= addr_q + ADDR_W'(STEP);
            wbuf_q <= wbuf_shift;
            rbuf_q <= rbuf_next;
            left_q <= left_q - CNT_W'(1);
        end
    end

    always_comb begin
        word_addr       = addr_q;
        word_data       = wbuf_q[CORE_W-1 -: BUS_W];
        word_we         = we_q;
        read_word       = rbuf_q;
        words_left_zero = (left_q == '0);
    end

endmodule

// File: rtl/lwsy_drive.sv
module lwsy_drive
    import lwsy_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CORE_W = 32,
    parameter int BUS_W  = 16
) (
    input  lwsy_state_e       state,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [BUS_W-1:0]  word_data,
    input  logic              word_we,
    input  logic [CORE_W-1:0] read_word,
    output logic              bus_stb,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BUS_W-1:0]  bus_wdata,
    output logic              ext_bgnt,
    output logic              core_ack,
    output logic [CORE_W-1:0] core_rdata
);

    // Output decode: bus lines only carry values inside a word cycle
    always_comb begin
        bus_stb    = 1'b0;
        bus_we     = 1'b0;
        bus_addr   = '0;
        bus_wdata  = '0;
        ext_bgnt   = 1'b0;
        core_ack   = 1'b0;
        core_rdata = '0;
        unique case (state)
            ST_WORD: begin
                bus_stb   = 1'b1;
                bus_we    = word_we;
                bus_addr  = word_addr;
                bus_wdata = word_we ? word_data : '0;
            end
            ST_YIELD: ext_bgnt = 1'b1;
            ST_DONE: begin
                core_ack   = 1'b1;
                core_rdata = read_word;
            end
            ST_IDLE, ST_GAP: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/lw_split_yield.sv
module lw_split_yield
    import lwsy_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CORE_W = 32,
    parameter int BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_we,
    input  logic              core_long,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [CORE_W-1:0] core_wdata,
    output logic              core_ack,
    output logic [CORE_W-1:0] core_rdata,
    output logic              bus_stb,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_ack,
    input  logic [BUS_W-1:0]  bus_rdata,
    input  logic              ext_breq,
    output logic              ext_bgnt
);

    lwsy_state_e       state;
    logic              load;
    logic              word_done;
    logic              words_left_zero;
    logic [ADDR_W-1:0] word_addr;
    logic [BUS_W-1:0]  word_data;
    logic              word_we;
    logic [CORE_W-1:0] read_word;

    lwsy_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .core_req        (core_req),
        .ext_breq        (ext_breq),
        .bus_ack         (bus_ack),
        .words_left_zero (words_left_zero),
        .state           (state),
        .load            (load),
        .word_done       (word_done)
    );

    lwsy_xfer #(.ADDR_W(ADDR_W), .CORE_W(CORE_W), .BUS_W(BUS_W)) u_xfer (
        .clk             (clk),
        .rst_n           (rst_n),
        .load            (load),
        .word_done       (word_done),
        .core_we         (core_we),
        .core_long       (core_long),
        .core_addr       (core_addr),
        .core_wdata      (core_wdata),
        .bus_rdata       (bus_rdata),
        .word_addr       (word_addr),
        .word_data       (word_data),
        .word_we         (word_we),
        .read_word       (read_word),
        .words_left_zero (words_left_zero)
    );

    lwsy_drive #(.ADDR_W(ADDR_W), .CORE_W(CORE_W), .BUS_W(BUS_W)) u_drive (
        .state      (state),
        .word_addr  (word_addr),
        .word_data  (word_data),
        .word_we    (word_we),
        .read_word  (read_word),
        .bus_stb    (bus_stb),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .ext_bgnt   (ext_bgnt),
        .core_ack   (core_ack),
        .core_rdata (core_rdata)
    );

endmodule

// File: rtl/lwsy_chk.sv
module lwsy_chk #(
    parameter int ADDR_W = 24,
    parameter int BUS_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_ack,
    input logic              bus_stb,
    input logic              bus_ack,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              ext_breq,
    input logic              ext_bgnt
);

    // R7: a parked bus drives nothing
    p_grant_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_bgnt |-> (!bus_stb && !bus_we && bus_addr == '0 && bus_wdata == '0));

    // R5: a started word cycle holds until acknowledged
    p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && !bus_ack) |=> (bus_stb && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_wdata)));

    // R6: a gap cycle follows every completed word
    p_gap_after_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && bus_ack) |=> !bus_stb);

    // R6: grant is only given in answer to a request
    p_grant_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_bgnt) |-> $past(ext_breq));

    // R8: grant withdrawn once the request is gone
    p_grant_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_bgnt && !ext_breq) |=> !ext_bgnt);

    // R4: completion is a single-cycle pulse
    p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack |=> !core_ack);

    // R9: completion never overlaps bus activity or grant
    p_ack_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack |-> (!bus_stb && !ext_bgnt));

endmodule

bind lw_split_yield lwsy_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_ack  (core_ack),
    .bus_stb   (bus_stb),
    .bus_ack   (bus_ack),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ext_breq  (ext_breq),
    .ext_bgnt  (ext_bgnt)
);

// File: tb/lw_split_yield_bench.sv
`timescale 1ns/1ps
module lw_split_yield_bench;

    localparam int AW = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 1'b0;
    logic        core_we = 1'b0;
    logic        core_long = 1'b0;
    logic [23:0] core_addr = '0;
    logic [31:0] core_wdata = '0;
    logic        core_ack;
    logic [31:0] core_rdata;
    logic        bus_stb;
    logic        bus_we;
    logic [23:0] bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        breq_env = 1'b0;
    logic        breq_man = 1'b0;
    logic        ext_breq;
    logic        ext_bgnt;

    assign ext_breq = breq_env | breq_man;

    always #2.5 clk = ~clk;

    lw_split_yield u_lw_split_yield (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_we(core_we), .core_long(core_long),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .core_ack(core_ack), .core_rdata(core_rdata),
        .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .ext_breq(ext_breq), .ext_bgnt(ext_bgnt)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_word(input logic [23:0] a);
        return a[15:0] ^ 16'hA5C3;
    endfunction

    // Configuration written by the driver, read by the environment
    int         lat_g = 0;
    bit         yield_en = 1'b0;
    logic [7:0] yield_beat = '0;
    bit         yield_resume = 1'b0;

    // Environment state
    logic [7:0]  beat_cnt = '0;
    logic [23:0] log_addr [256];
    logic        log_we   [256];
    logic [15:0] log_data [256];
    bit          in_beat = 1'b0;
    int          wcnt = 0;
    logic [23:0] f_addr;
    logic        f_we;
    logic [15:0] f_data;
    int          ymst = 0;
    int          ywait = 0;
    int          yhold = 0;

    // Slave and external master model, all sampling at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            case (ymst)
                1: check(!ext_bgnt, "R6 no grant mid-word", 32'(ext_bgnt), 0);
                2: begin
                    ywait++;
                    if (ext_bgnt) begin
                        check(ywait == 2, "R6 grant delay", ywait, 2);
                        check(!bus_stb && !bus_we && bus_addr == 0 && bus_wdata == 0,
                              "R7 parked bus", {bus_stb, bus_we, bus_addr[13:0], bus_wdata}, 0);
                        yhold = 0;
                        ymst = 3;
                    end else if (ywait > 2) begin
                        check(1'b0, "R6 grant missing", 0, 1);
                        breq_env = 1'b0;
                        ymst = 0;
                    end
                end
                3: begin
                    yhold++;
                    check(ext_bgnt && !bus_stb, "R7 grant held", {ext_bgnt, bus_stb}, 2'b10);
                    if (yhold == 3) begin
                        breq_env = 1'b0;
                        ymst = 4;
                    end
                end
                4: begin
                    check(!ext_bgnt, "R8 grant drop", 32'(ext_bgnt), 0);
                    if (yield_resume)
                        check(bus_stb, "R8 resume strobe", 32'(bus_stb), 1);
                    else
                        check(core_ack, "R9 ack after yield", 32'(core_ack), 1);
                    ymst = 0;
                end
                default: ;
            endcase

            if (bus_ack) begin
                bus_ack = 1'b0;
                in_beat = 1'b0;
            end else if (bus_stb) begin
                if (!in_beat) begin
                    in_beat = 1'b1;
                    wcnt = 0;
                    f_addr = bus_addr;
                    f_we = bus_we;
                    f_data = bus_wdata;
                    if (yield_en && ymst == 0 && beat_cnt == yield_beat) begin
                        breq_env = 1'b1;
                        ymst = 1;
                    end
                end else begin
                    wcnt++;
                    check(bus_addr == f_addr && bus_we == f_we && bus_wdata == f_data,
                          "R5 word held", {bus_addr[15:0], bus_wdata}, {f_addr[15:0], f_data});
                end
                if (wcnt == lat_g) begin
                    bus_ack = 1'b1;
                    bus_rdata = mem_word(bus_addr);
                    log_addr[beat_cnt] = bus_addr;
                    log_we[beat_cnt] = bus_we;
                    log_data[beat_cnt] = bus_wdata;
                    beat_cnt = beat_cnt + 8'd1;
                    if (ymst == 1) begin
                        ymst = 2;
                        ywait = 0;
                    end
                end
            end
        end
    end

    task automatic run_xfer(input bit we, input bit lng, input logic [23:0] addr,
                            input logic [31:0] wd, input int lat, input int ymode);
        logic [7:0]  base;
        logic [7:0]  n;
        logic [31:0] exp_r;
        @(negedge clk);
        base = beat_cnt;
        lat_g = lat;
        yield_en = (ymode != 0);
        yield_beat = base + ((ymode == 2 && lng) ? 8'd1 : 8'd0);
        yield_resume = lng && (ymode == 1);
        core_req = 1'b1;
        core_we = we;
        core_long = lng;
        core_addr = addr;
        core_wdata = wd;
        do @(negedge clk); while (!core_ack);
        n = beat_cnt - base;
        check(n == (lng ? 8'd2 : 8'd1), lng ? "R2 beat count" : "R3 beat count",
              32'(n), lng ? 2 : 1);
        check(log_addr[base] == addr && log_we[base] == we, "R2 first word addr",
              {7'd0, log_we[base], log_addr[base]}, {7'd0, we, addr});
        if (lng) begin
            check(log_addr[base + 8'd1] == addr + 24'd2, "R2 second word addr",
                  32'(log_addr[base + 8'd1]), 32'(addr + 24'd2));
            if (we) begin
                check(log_data[base] == wd[31:16], "R2 high word first",
                      32'(log_data[base]), 32'(wd[31:16]));
                check(log_data[base + 8'd1] == wd[15:0], "R2 low word second",
                      32'(log_data[base + 8'd1]), 32'(wd[15:0]));
            end
        end else if (we) begin
            check(log_data[base] == wd[15:0], "R3 short write data",
                  32'(log_data[base]), 32'(wd[15:0]));
        end
        if (!we) begin
            exp_r = lng ? {mem_word(addr), mem_word(addr + 24'd2)} : {16'h0, mem_word(addr)};
            check(core_rdata == exp_r, lng ? "R4 long read data" : "R3 short read data",
                  core_rdata, exp_r);
        end
        core_req = 1'b0;
        yield_en = 1'b0;
        @(negedge clk);
        check(!core_ack, "R4 ack one cycle", 32'(core_ack), 0);
        check(ymst == 0, "R6 yield handshake complete", ymst, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(!bus_stb && !bus_we && bus_addr == 0 && bus_wdata == 0,
              "R1 bus idle in reset", {bus_stb, bus_we, bus_addr[13:0], bus_wdata}, 0);
        check(!ext_bgnt && !core_ack && core_rdata == 0, "R1 core side idle",
              core_rdata, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!bus_stb && !ext_bgnt && !core_ack, "R1 idle after reset",
              {bus_stb, ext_bgnt, core_ack}, 0);

        // Sweep direction, size, slave latency and yield point
        for (int i = 0; i < 48; i++) begin
            automatic bit          we  = i[0];
            automatic bit          lng = i[1];
            automatic int          lat = (i >> 2) % 4;
            automatic int          ym  = i / 16;
            automatic logic [23:0] a   = 24'h0100 + 24'(i * 54);
            automatic logic [31:0] wd  = 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101);
            run_xfer(we, lng, a, wd, lat, ym);
        end

        // R10: bus request wins over a core request in IDLE
        @(negedge clk);
        lat_g = 1;
        breq_man = 1'b1;
        core_req = 1'b1;
        core_we = 1'b0;
        core_long = 1'b1;
        core_addr = 24'h00_2468;
        @(negedge clk);
        check(ext_bgnt && !bus_stb, "R10 idle grant first", {ext_bgnt, bus_stb}, 2'b10);
        repeat (2) @(negedge clk);
        check(ext_bgnt && !bus_stb, "R10 grant held", {ext_bgnt, bus_stb}, 2'b10);
        breq_man = 1'b0;
        @(negedge clk);
        check(!ext_bgnt && !bus_stb, "R10 grant drop", {ext_bgnt, bus_stb}, 0);
        @(negedge clk);
        check(bus_stb && bus_addr == 24'h00_2468, "R10 access starts after yield",
              32'(bus_addr), 32'h2468);
        do @(negedge clk); while (!core_ack);
        check(core_rdata == {mem_word(24'h2468), mem_word(24'h246A)}, "R4 data after idle yield",
              core_rdata, {mem_word(24'h2468), mem_word(24'h246A)});
        core_req = 1'b0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule